// File: doc/BRIEF.md
# Dual-Channel DAC Serial Load Controller

This block is the digital front end of a two-channel digital-to-analog converter. A host writes 16-bit words over a three-wire serial port: a frame strobe (active low), a serial clock and a data line. The block shifts each word in MSB first. It decodes a channel-select bit and a 12-bit code from the word. The code goes into the input register of the selected channel.

The two input registers reach the output code registers in one of two ways. The first is a falling edge on the load strobe, which moves both channels at the same time. The second applies when the load strobe is held low: both channels then update automatically once the 16th bit of a word has been taken. An active-low clear zeroes every register and holds it there. A format strap selects straight binary or twos-complement codes. In twos-complement mode the presented codes have their MSB inverted, so the converter behind the block always receives offset binary. All serial pins are brought into the system clock domain through synchronizers, and their edges are detected there.

Top module: `dual_dac_loader`

## Requirements
- R1: After synchronous reset both output codes read 12'h000 with the format strap low, and both input registers hold zero.
- R2: A word is 16 bits, sampled on falling serial-clock edges while the frame strobe is low, first bit = bit 15. Bit 15 selects the channel (0 = A, 1 = B). Bits 11..0 are the code. Bits 14..12 have no effect.
- R3: A completed word changes only the input register of the channel it selects; the other channel keeps its value.
- R4: While the load strobe stays high, a completed word leaves both output codes unchanged. A falling edge of the load strobe copies both input registers to both outputs together.
- R5: While the load strobe is held low, both outputs take the input registers, including the word just received, as soon as the 16th falling serial-clock edge has been taken.
- R6: If the frame strobe rises before 16 bits have arrived, the partial word is discarded and no register changes.
- R7: Each low period of the frame strobe starts a fresh word from bit 15, whatever happened in the previous frame.
- R8: While the clear input is low, both input and both output registers hold zero.
- R9: Serial words that arrive while clear is low are ignored, and the registers still hold zero after clear returns high.
- R10: With the format strap high, each output code equals the stored code with bit 11 inverted, so the cleared state reads 12'h800.
- R11: Serial-clock edges after the 16th within one frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_frame_n | input | 1 | Frame strobe, active low |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load strobe: falling edge transfers, held low selects auto-update |
| clr_n | input | 1 | Clear, active low |
| fmt_twos | input | 1 | Code format: 0 straight binary, 1 twos complement |
| code_a | output | 12 | Presented code of channel A |
| code_b | output | 12 | Presented code of channel B |

## Verification
Walking-one codes on each channel, with the spare bits varied, separate a swapped or shifted bit field from a correct decode and expose any leak into the other channel. A strided sweep across the code range in auto-update mode tests transfer timing. Direct checks cover manual load ordering and truncated frames. Over-long frames, writes during clear, and the twos-complement view of the same stored codes each isolate one control path.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    localparam int WORD_W  = 16;
    localparam int CODE_W  = 12;
    localparam int SPARE_W = WORD_W - CODE_W - 1;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int N_CHAN  = 2;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        chan_e               chan;
        logic [SPARE_W-1:0]  spare;
        logic [CODE_W-1:0]   code;
    } word_t;

    typedef logic [CODE_W-1:0] code_t;

    // Converts the stored code to the straight-binary form seen downstream.
    function automatic code_t present_code(input code_t raw, input logic twos);
        code_t msb;
        msb = '0;
        msb[CODE_W-1] = 1'b1;
        return twos ? (raw ^ msb) : raw;
    endfunction

endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
    parameter int       W       = 1,
    parameter int       STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacld_shifter.sv
module dacld_shifter
    import dacld_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,
    input  logic  frame_n_s,
    input  logic  sdata_s,
    output word_t word_q,
    output logic  word_done
);
    localparam int CW = $clog2(WW + 1);

    logic          sclk_d;
    logic [CW-1:0] cnt;
    logic [WW-1:0] sh;
    logic          fall;

    assign fall = sclk_d & ~sclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b1;
            cnt       <= '0;
            sh        <= '0;
            word_done <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            word_done <= 1'b0;
            if (frame_n_s) begin
                cnt <= '0;
            end else if (fall && (cnt < CW'(WW))) begin
                sh  <= {sh[WW-2:0], sdata_s};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(WW - 1)) word_done <= 1'b1;
            end
        end
    end

    assign word_q = word_t'(sh[WORD_W-1:0]);
endmodule

// File: rtl/dacld_regs.sv
module dacld_regs
    import dacld_pkg::*;
#(
    parameter int NC = N_CHAN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_n_s,
    input  logic  load_n_s,
    input  logic  word_done,
    input  word_t word,
    output code_t in_r  [NC],
    output code_t out_r [NC],
    output logic  load_fall
);
    logic load_d;
    logic auto_upd;

    always_ff @(posedge clk) begin
        if (rst) load_d <= 1'b1;
        else     load_d <= load_n_s;
    end

    assign load_fall = load_d & ~load_n_s;
    assign auto_upd  = word_done & ~load_n_s;

    generate
        for (genvar ch = 0; ch < NC; ch++) begin : g_chan
            logic hit;
            assign hit = word_done && (int'(word.chan) == ch);

            always_ff @(posedge clk) begin
                if (rst || !clr_n_s) begin
                    in_r[ch]  <= '0;
                    out_r[ch] <= '0;
                end else begin
                    if (hit) in_r[ch] <= word.code;
                    if (auto_upd)       out_r[ch] <= hit ? word.code : in_r[ch];
                    else if (load_fall) out_r[ch] <= in_r[ch];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacld_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_frame_n,
    input  logic              ser_data,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic              fmt_twos,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    localparam int NPIN = 5;

    logic [NPIN-1:0] pins_raw, pins_s;
    logic  sclk_s, frame_n_s, sdata_s, load_n_s, clr_n_s;
    word_t word;
    logic  word_done;
    logic  load_fall;
    code_t in_r  [N_CHAN];
    code_t out_r [N_CHAN];
    code_t in_a, in_b, out_a, out_b;

    assign pins_raw = {ser_clk, ser_frame_n, ser_data, load_n, clr_n};

    dacld_sync #(
        .W      (NPIN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b11011)
    ) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    assign {sclk_s, frame_n_s, sdata_s, load_n_s, clr_n_s} = pins_s;

    dacld_shifter #(.WW(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (sclk_s),
        .frame_n_s(frame_n_s),
        .sdata_s  (sdata_s),
        .word_q   (word),
        .word_done(word_done)
    );

    dacld_regs #(.NC(N_CHAN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .clr_n_s  (clr_n_s),
        .load_n_s (load_n_s),
        .word_done(word_done),
        .word     (word),
        .in_r     (in_r),
        .out_r    (out_r),
        .load_fall(load_fall)
    );

    assign in_a  = in_r[0];
    assign in_b  = in_r[1];
    assign out_a = out_r[0];
    assign out_b = out_r[1];

    assign code_a = present_code(out_a, fmt_twos);
    assign code_b = present_code(out_b, fmt_twos);
endmodule

// File: rtl/dacld_checker.sv
module dacld_checker
    import dacld_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  clr_n_s,
    input logic  load_n_s,
    input logic  load_fall,
    input logic  word_done,
    input code_t in_a,
    input code_t in_b,
    input code_t out_a,
    input code_t out_b
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_a == '0 && out_b == '0 && in_a == '0 && in_b == '0)); // R1

    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        word_done |=> ($stable(in_a) || $stable(in_b))); // R3

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (clr_n_s && !load_fall && !(word_done && !load_n_s))
            |=> ($stable(out_a) && $stable(out_b))); // R4

    AST_AUTO_COPY: assert property (@(posedge clk) disable iff (rst)
        (word_done && !load_n_s && clr_n_s) |=> (out_a == in_a && out_b == in_b)); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !clr_n_s |=> (out_a == '0 && out_b == '0 && in_a == '0 && in_b == '0)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done); // R11
endmodule

bind dual_dac_loader dacld_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_n_s  (clr_n_s),
    .load_n_s (load_n_s),
    .load_fall(load_fall),
    .word_done(word_done),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        frame_n = 1'b1;
    logic        sdata = 1'b0;
    logic        load_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        fmt_twos = 1'b0;
    logic [11:0] code_a, code_b;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [11:0] exp_in  [2];
    logic [11:0] exp_out [2];

    always #2 clk = ~clk;

    dual_dac_loader u_dual_dac_loader (
        .clk(clk), .rst(rst), .ser_clk(sclk), .ser_frame_n(frame_n),
        .ser_data(sdata), .load_n(load_n), .clr_n(clr_n), .fmt_twos(fmt_twos),
        .code_a(code_a), .code_b(code_b)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [11:0] pres(input logic [11:0] raw);
        return fmt_twos ? (raw ^ 12'h800) : raw;
    endfunction

    task automatic check_outs(input string req);
        total++;
        if (code_a !== pres(exp_out[0]) || code_b !== pres(exp_out[1])) begin
            bad++;
            $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h",
                     req, code_a, code_b, pres(exp_out[0]), pres(exp_out[1]));
        end
    endtask

    // Sends nbits clock pulses; bits past 16 carry ones.
    task automatic send(input logic [15:0] w, input int nbits);
        frame_n = 1'b0;
        tick(3);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 16) ? w[15-i] : 1'b1;
            tick(3);
            sclk = 1'b0;
            tick(3);
            sclk = 1'b1;
        end
        tick(3);
        frame_n = 1'b1;
        tick(8);
        if (nbits >= 16 && clr_n) begin
            exp_in[w[15]] = w[11:0];
            if (!load_n) begin
                exp_out[0] = exp_in[0];
                exp_out[1] = exp_in[1];
            end
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        tick(6);
        load_n = 1'b1;
        tick(6);
        if (clr_n) begin
            exp_out[0] = exp_in[0];
            exp_out[1] = exp_in[1];
        end
    endtask

    task automatic set_auto(input logic on);
        load_n = !on;
        tick(6);
        if (on && clr_n) begin
            exp_out[0] = exp_in[0];
            exp_out[1] = exp_in[1];
        end
    endtask

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_in[0] = '0; exp_in[1] = '0; exp_out[0] = '0; exp_out[1] = '0;
        tick(5);
        rst = 1'b0;
        tick(4);
        check_outs("R1 reset");

        // R2 R3 R4: walking ones on both channels, spare bits varied
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < 12; k++) begin
                logic [15:0] w;
                w = {ch[0], 3'(k), 12'(1 << k)};
                send(w, 16);
                check_outs("R4 hold before load");
                pulse_load();
                check_outs("R2 R3 decode and steer");
            end
        end

        // R5: auto-update sweep
        set_auto(1'b1);
        for (int v = 0; v < 4096; v += 53) begin
            send({v[0], 3'b101, 12'(v)}, 16);
            check_outs("R5 auto update");
        end
        set_auto(1'b0);

        // R6: truncated frame discarded
        send({1'b0, 3'b000, 12'h5A5}, 9);
        pulse_load();
        check_outs("R6 partial discarded");
        // R7: next frame restarts cleanly
        send({1'b1, 3'b000, 12'h3C3}, 16);
        pulse_load();
        check_outs("R7 fresh frame");

        // R11: extra clock edges ignored
        send({1'b0, 3'b010, 12'h0F0}, 20);
        pulse_load();
        check_outs("R11 extra edges");

        // R8: clear
        clr_n = 1'b0;
        tick(6);
        exp_in[0] = '0; exp_in[1] = '0; exp_out[0] = '0; exp_out[1] = '0;
        check_outs("R8 clear");
        // R9: writes ignored during clear, manual and auto
        send({1'b0, 3'b000, 12'hABC}, 16);
        set_auto(1'b1);
        send({1'b1, 3'b000, 12'h123}, 16);
        set_auto(1'b0);
        clr_n = 1'b1;
        tick(6);
        check_outs("R9 after clear release");
        pulse_load();
        check_outs("R9 ignored writes");

        // R10: twos-complement presentation
        fmt_twos = 1'b1;
        tick(2);
        check_outs("R10 clear midscale");
        total++;
        if (code_a !== 12'h800) begin
            bad++;
            $display("FAIL R10: actual=%h expected=800", code_a);
        end
        for (int v = 0; v < 4096; v += 511) begin
            send({1'b0, 3'b000, 12'(v)}, 16);
            send({1'b1, 3'b000, 12'(4095 - v)}, 16);
            pulse_load();
            check_outs("R10 msb inverted");
        end
        fmt_twos = 1'b0;
        tick(2);
        check_outs("R10 binary view");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule